// File: doc/BRIEF.md
# Multi-Zone Automatic Fan Duty Controller

This block works out the 8-bit target duty for one fan output from three zone temperatures. Each temperature is an 8-bit two's complement value, and each zone has its own settings: a start temperature, a window width, a floor duty, a hysteresis margin and an emergency limit. A 3-bit mode chooses where the duty comes from. It can follow one zone, take the largest demand from a group of zones, hold full speed, stay off, or pass through a duty written by the host.

Inside the window the duty rises in a straight line from the zone's floor duty up to full scale. Below the window, one shared policy bit chooses what happens. Either the fan stays at the floor duty, or it stops, and in that case it stops only after the temperature has dropped a hysteresis margin below the start point. A temperature at or above its emergency limit forces full duty in every mode. So does a sensor-error reading in a zone that takes part.

When the output leaves zero, the controller first drives full duty for a programmable kick time, so that a stalled fan can start. That kick can be cut short as soon as a tachometer-healthy indication arrives. The block hands its result to a separate ramp limiter and PWM generator.

Top module: `fan_duty_ctrl`

## Requirements
- R1: For a zone with T_lo <= T < T_lo + W, the zone demand is floor + floor((FFh - floor) * (T - T_lo) / W), computed in integers. T_lo is a signed start temperature, W an unsigned width in degrees and floor the zone's floor duty.
- R2: For T >= T_lo + W, the zone demand is FFh.
- R3: When `below_off` = 0 and T < T_lo, the zone demand is the zone's floor duty.
- R4: When `below_off` = 1, a zone that is running keeps its floor duty for as long as T >= T_lo - H, where H is the zone's unsigned hysteresis value. Once T drops below that point, the demand is 00h, and it stays 00h until T reaches T_lo again.
- R5: Any zone whose temperature (when not 80h) is at or above its signed emergency limit forces the output to FFh, whatever the mode.
- R6: A temperature of 80h is a sensor error, and it makes that zone's demand FFh. A zone with an error that does not take part in the selected mode has no effect on the output.
- R7: The mode encoding is: 0 = zone 1, 1 = zone 2, 2 = zone 3, 3 = always FFh, 4 = off (00h), 7 = `manual_duty`.
- R8: Mode 5 outputs the larger demand of zones 2 and 3. Mode 6 outputs the largest demand of zones 1, 2 and 3.
- R9: When the output is 00h and the target becomes non-zero, the output is FFh for `spin_code` × SPIN_TICKS cycles and then equals the target. A `spin_code` of 0 gives no kick.
- R10: With `spin_fast_en` = 1, a kick that is in progress ends when `tach_good` is 1, and the output takes the target value on the following cycle.
- R11: The output is registered. It is 00h while `rst_n` is low, and it reflects its inputs one clock later.

Zones are numbered 1 to 3 here. In the packed array ports, index 0 is zone 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 3 | Duty source select (R7, R8) |
| zone_temp | input | 3x8 | Zone temperatures, two's complement, 80h = error |
| zone_tlo | input | 3x8 | Signed start temperature per zone |
| zone_width | input | 3x8 | Unsigned window width per zone |
| zone_floor | input | 3x8 | Floor duty per zone |
| zone_hyst | input | 3x8 | Unsigned hysteresis margin per zone |
| zone_limit | input | 3x8 | Signed emergency limit per zone |
| below_off | input | 1 | 1 = stop below the window, 0 = hold the floor duty |
| manual_duty | input | 8 | Duty used in manual mode |
| spin_code | input | 3 | Kick length in units of SPIN_TICKS cycles |
| spin_fast_en | input | 1 | Allows early end of the kick |
| tach_good | input | 1 | Fan tachometer reports normal speed |
| duty_out | output | 8 | Registered target duty |

## Verification
A table of vectors steps single-zone temperatures through the points below, inside, at the top of and above the window. These points separate truncation errors, off-by-one edges at T_lo and T_lo + W, and a mixed-up floor versus zero. The same table also holds all eight modes and hottest-of cases in which a different zone wins. That shows whether zone membership and the max selection are decoded properly. Further vectors place an emergency limit or an error code in a zone outside the selected mode, which separates the global override from the per-zone error rule. Directed sequences then walk the temperature down through the hysteresis band and count the exact kick length, with and without the tachometer early exit.

// File: rtl/fan_duty_pkg.sv
package fan_duty_pkg;
    localparam int NZONE = 3;

    typedef enum logic [2:0] {
        SRC_ZONE1  = 3'd0,
        SRC_ZONE2  = 3'd1,
        SRC_ZONE3  = 3'd2,
        SRC_FULL   = 3'd3,
        SRC_OFF    = 3'd4,
        SRC_HOT23  = 3'd5,
        SRC_HOT123 = 3'd6,
        SRC_MANUAL = 3'd7
    } duty_src_e;
endpackage

// File: rtl/fan_zone_curve.sv
module fan_zone_curve #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] temp,
    input  logic [DW-1:0] tlo,
    input  logic [DW-1:0] width,
    input  logic [DW-1:0] floor_duty,
    input  logic [DW-1:0] hyst,
    input  logic [DW-1:0] limit,
    input  logic          below_off,
    output logic [DW-1:0] demand,
    output logic          limit_hit
);
    localparam int EW = DW + 2;
    localparam int PW = 2 * DW + 2;
    localparam logic [DW-1:0] FULL = '1;
    localparam logic [DW-1:0] ERR_CODE = {1'b1, {(DW-1){1'b0}}};

    logic signed [EW-1:0] t_s, tlo_s, top_s, keep_s, lim_s, diff_s;
    logic [PW-1:0] prod, quo, level;
    logic [DW-1:0] span, divisor;
    logic run_d, run_q, err;

    always_comb begin
        t_s    = {{2{temp[DW-1]}}, temp};
        tlo_s  = {{2{tlo[DW-1]}}, tlo};
        lim_s  = {{2{limit[DW-1]}}, limit};
        top_s  = tlo_s + $signed({2'b00, width});
        keep_s = tlo_s - $signed({2'b00, hyst});
        diff_s = t_s - tlo_s;
        span   = FULL - floor_duty;
        divisor = (width == '0) ? {{(DW-1){1'b0}}, 1'b1} : width;
        prod   = PW'(span) * PW'($unsigned(diff_s));
        quo    = prod / PW'(divisor);
        level  = PW'(floor_duty) + quo;
        err    = (temp == ERR_CODE);
        limit_hit = !err && (t_s >= lim_s);

        run_d  = run_q;
        if (err || t_s >= top_s) begin
            demand = FULL;
            run_d  = 1'b1;
        end else if (t_s >= tlo_s) begin
            demand = (level > PW'(FULL)) ? FULL : level[DW-1:0];
            run_d  = 1'b1;
        end else if (!below_off) begin
            demand = floor_duty;
            run_d  = 1'b1;
        end else if (run_q && t_s >= keep_s) begin
            demand = floor_duty;
        end else begin
            demand = '0;
            run_d  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= run_d;
    end
endmodule

// File: rtl/fan_mode_select.sv
module fan_mode_select
    import fan_duty_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [2:0]                mode,
    input  logic [NZONE-1:0][DW-1:0]  demand,
    input  logic                      limit_any,
    input  logic [DW-1:0]             manual_duty,
    output logic [DW-1:0]             target
);
    logic [DW-1:0] hot23, hot123;

    always_comb begin
        hot23  = (demand[1] > demand[2]) ? demand[1] : demand[2];
        hot123 = (demand[0] > hot23) ? demand[0] : hot23;
        case (duty_src_e'(mode))
            SRC_ZONE1:  target = demand[0];
            SRC_ZONE2:  target = demand[1];
            SRC_ZONE3:  target = demand[2];
            SRC_FULL:   target = '1;
            SRC_OFF:    target = '0;
            SRC_HOT23:  target = hot23;
            SRC_HOT123: target = hot123;
            default:    target = manual_duty;
        endcase
        if (limit_any) target = '1;
    end
endmodule

// File: rtl/fan_duty_ctrl.sv
module fan_duty_ctrl
    import fan_duty_pkg::*;
#(
    parameter int DW         = 8,
    parameter int SPIN_TICKS = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [2:0]                mode,
    input  logic [NZONE-1:0][DW-1:0]  zone_temp,
    input  logic [NZONE-1:0][DW-1:0]  zone_tlo,
    input  logic [NZONE-1:0][DW-1:0]  zone_width,
    input  logic [NZONE-1:0][DW-1:0]  zone_floor,
    input  logic [NZONE-1:0][DW-1:0]  zone_hyst,
    input  logic [NZONE-1:0][DW-1:0]  zone_limit,
    input  logic                      below_off,
    input  logic [DW-1:0]             manual_duty,
    input  logic [2:0]                spin_code,
    input  logic                      spin_fast_en,
    input  logic                      tach_good,
    output logic [DW-1:0]             duty_out
);
    localparam int SPIN_CW = $clog2(7 * SPIN_TICKS + 1);

    typedef struct packed {
        logic [DW-1:0]      duty;
        logic [SPIN_CW-1:0] kick;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic [NZONE-1:0][DW-1:0] demand;
    logic [NZONE-1:0]         hit;
    logic [DW-1:0]            target;
    logic [SPIN_CW-1:0]       kick_len;
    logic                     fast_exit;

    for (genvar z = 0; z < NZONE; z++) begin : g_zone
        fan_zone_curve #(.DW(DW)) u_curve (
            .clk        (clk),
            .rst_n      (rst_n),
            .temp       (zone_temp[z]),
            .tlo        (zone_tlo[z]),
            .width      (zone_width[z]),
            .floor_duty (zone_floor[z]),
            .hyst       (zone_hyst[z]),
            .limit      (zone_limit[z]),
            .below_off  (below_off),
            .demand     (demand[z]),
            .limit_hit  (hit[z])
        );
    end

    fan_mode_select #(.DW(DW)) u_select (
        .mode        (mode),
        .demand      (demand),
        .limit_any   (|hit),
        .manual_duty (manual_duty),
        .target      (target)
    );

    always_comb begin
        st_d      = st_q;
        kick_len  = SPIN_CW'(spin_code) * SPIN_CW'(SPIN_TICKS);
        fast_exit = spin_fast_en && tach_good;
        if (target == '0) begin
            st_d.duty = '0;
            st_d.kick = '0;
        end else if (st_q.kick != '0) begin
            if (fast_exit) begin
                st_d.duty = target;
                st_d.kick = '0;
            end else begin
                st_d.duty = '1;
                st_d.kick = st_q.kick - 1'b1;
            end
        end else if (st_q.duty == '0 && kick_len != '0 && !fast_exit) begin
            st_d.duty = '1;
            st_d.kick = kick_len - 1'b1;
        end else begin
            st_d.duty = target;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign duty_out = st_q.duty;
endmodule

// File: rtl/fan_duty_ctrl_chk.sv
module fan_duty_ctrl_chk
    import fan_duty_pkg::*;
#(
    parameter int DW = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [2:0]                mode,
    input logic [NZONE-1:0][DW-1:0]  zone_temp,
    input logic [NZONE-1:0][DW-1:0]  zone_limit,
    input logic [DW-1:0]             manual_duty,
    input logic [2:0]                spin_code,
    input logic                      spin_fast_en,
    input logic                      tach_good,
    input logic [DW-1:0]             duty_out
);
    localparam logic [DW-1:0] ERR_CODE = {1'b1, {(DW-1){1'b0}}};
    logic over_any;

    always_comb begin
        over_any = 1'b0;
        for (int z = 0; z < NZONE; z++)
            if (zone_temp[z] != ERR_CODE && $signed(zone_temp[z]) >= $signed(zone_limit[z]))
                over_any = 1'b1;
    end

    a_r5_limit_full: assert property (@(posedge clk) disable iff (!rst_n)
        over_any |=> duty_out == '1);
    a_r6_error_zone1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SRC_ZONE1 && zone_temp[0] == ERR_CODE) |=> duty_out == '1);
    a_r7_full_mode: assert property (@(posedge clk) disable iff (!rst_n)
        mode == SRC_FULL |=> duty_out == '1);
    a_r7_off_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SRC_OFF && !over_any) |=> duty_out == '0);
    a_r9_kick_start: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_out == '0 && mode == SRC_MANUAL && manual_duty != '0 && spin_code != 3'd0
         && !(spin_fast_en && tach_good)) |=> duty_out == '1);
endmodule

bind fan_duty_ctrl fan_duty_ctrl_chk #(.DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode         (mode),
    .zone_temp    (zone_temp),
    .zone_limit   (zone_limit),
    .manual_duty  (manual_duty),
    .spin_code    (spin_code),
    .spin_fast_en (spin_fast_en),
    .tach_good    (tach_good),
    .duty_out     (duty_out)
);

// File: tb/fan_duty_ctrl_test.sv
module fan_duty_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic clk = 1'b0;
    logic rst_n;
    logic [2:0] mode;
    logic [2:0][7:0] zone_temp, zone_tlo, zone_width, zone_floor, zone_hyst, zone_limit;
    logic below_off;
    logic [7:0] manual_duty;
    logic [2:0] spin_code;
    logic spin_fast_en, tach_good;
    logic [7:0] duty_out;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fan_duty_ctrl uut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .zone_temp(zone_temp),
        .zone_tlo(zone_tlo), .zone_width(zone_width), .zone_floor(zone_floor),
        .zone_hyst(zone_hyst), .zone_limit(zone_limit), .below_off(below_off),
        .manual_duty(manual_duty), .spin_code(spin_code), .spin_fast_en(spin_fast_en),
        .tach_good(tach_good), .duty_out(duty_out)
    );

    typedef struct packed {
        logic [23:0] tag;
        logic [2:0]  mode;
        logic [7:0]  t1, t2, t3;
        logic [7:0]  exp;
    } vec_t;

    // zone1: start 40, width 20, floor 128 ; zone2: start 30, width 40, floor 64
    // zone3: start 50, width 10, floor 0 ; limits 100 / 90 / 110 ; manual 5Ah
    localparam int NVEC = 17;
    localparam vec_t VEC [NVEC] = '{
        '{"R1 ", 3'd0, 8'd50,  8'd0,  8'd0,  8'd191}, // R1 mid window
        '{"R1 ", 3'd0, 8'd40,  8'd0,  8'd0,  8'd128}, // R1 window start
        '{"R1 ", 3'd0, 8'd59,  8'd0,  8'd0,  8'd248}, // R1 last step
        '{"R2 ", 3'd0, 8'd60,  8'd0,  8'd0,  8'd255}, // R2 window top
        '{"R3 ", 3'd0, 8'd30,  8'd0,  8'd0,  8'd128}, // R3 floor below
        '{"R7 ", 3'd1, 8'd0,   8'd50, 8'd0,  8'd159}, // R7 zone2
        '{"R3 ", 3'd1, 8'd0,   8'hEC, 8'd0,  8'd64},  // R3 negative temp
        '{"R7 ", 3'd2, 8'd0,   8'd0,  8'd55, 8'd127}, // R7 zone3
        '{"R7 ", 3'd3, 8'd0,   8'd0,  8'd0,  8'd255}, // R7 full
        '{"R7 ", 3'd4, 8'd0,   8'd0,  8'd0,  8'd0},   // R7 off
        '{"R8 ", 3'd5, 8'd60,  8'd50, 8'd55, 8'd159}, // R8 zone1 excluded
        '{"R8 ", 3'd6, 8'd60,  8'd50, 8'd55, 8'd255}, // R8 zone1 wins
        '{"R7 ", 3'd7, 8'd0,   8'd0,  8'd0,  8'h5A},  // R7 manual
        '{"R5 ", 3'd4, 8'd0,   8'd0,  8'd110,8'd255}, // R5 limit in off mode
        '{"R5 ", 3'd0, 8'd0,   8'd90, 8'd0,  8'd255}, // R5 other zone limit
        '{"R6 ", 3'd0, 8'h80,  8'd0,  8'd0,  8'd255}, // R6 error in zone
        '{"R6 ", 3'd1, 8'h80,  8'd0,  8'd0,  8'd64}   // R6 error ignored
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: duty_out=%0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_t1(input logic [7:0] t);
        zone_temp[0] = t;
        @(negedge clk);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        mode = 3'd3;
        zone_temp  = '0;
        zone_tlo   = {8'd50, 8'd30, 8'd40};
        zone_width = {8'd10, 8'd40, 8'd20};
        zone_floor = {8'd0,  8'd64, 8'd128};
        zone_hyst  = {8'd5,  8'd5,  8'd5};
        zone_limit = {8'd110, 8'd90, 8'd100};
        below_off = 1'b0;
        manual_duty = 8'h5A;
        spin_code = 3'd0;
        spin_fast_en = 1'b0;
        tach_good = 1'b0;
        repeat (3) @(negedge clk);
        check("R11 reset", duty_out, 8'h00);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            mode = VEC[i].mode;
            zone_temp = {VEC[i].t3, VEC[i].t2, VEC[i].t1};
            @(negedge clk);
            check(string'(VEC[i].tag), duty_out, VEC[i].exp);
        end

        // R4 hysteresis with stop policy, zone1 start 40, margin 5
        mode = 3'd0; below_off = 1'b1; zone_temp = '0;
        set_t1(8'd30); check("R4 below idle", duty_out, 8'd0);
        set_t1(8'd40); check("R4 start", duty_out, 8'd128);
        set_t1(8'd36); check("R4 in band", duty_out, 8'd128);
        set_t1(8'd35); check("R4 band edge", duty_out, 8'd128);
        set_t1(8'd34); check("R4 stop", duty_out, 8'd0);
        set_t1(8'd36); check("R4 stays off", duty_out, 8'd0);

        // R9 kick: code 2 x 4 ticks = 8 cycles of FFh
        mode = 3'd4; @(negedge clk);
        check("R9 pre off", duty_out, 8'd0);
        mode = 3'd7; manual_duty = 8'h30; spin_code = 3'd2;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            check("R9 kick", duty_out, 8'hFF);
        end
        @(negedge clk);
        check("R9 after kick", duty_out, 8'h30);

        // R10 early end of the kick
        mode = 3'd4; @(negedge clk);
        mode = 3'd7; spin_fast_en = 1'b1; tach_good = 1'b0;
        @(negedge clk); check("R10 kick", duty_out, 8'hFF);
        @(negedge clk); check("R10 kick", duty_out, 8'hFF);
        tach_good = 1'b1;
        @(negedge clk); check("R10 early exit", duty_out, 8'h30);

        // R9 code 0 gives no kick
        mode = 3'd4; spin_fast_en = 1'b0; tach_good = 1'b0; spin_code = 3'd0;
        @(negedge clk);
        mode = 3'd7;
        @(negedge clk); check("R9 no kick", duty_out, 8'h30);

        // R11 reset returns output to zero
        rst_n = 1'b0;
        @(negedge clk); check("R11 reset again", duty_out, 8'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule